// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break and Compare Events

This block turns an asynchronous serial line into characters. It takes one sample per `sample_en` pulse. In the oversampled mode there are sixteen samples per bit. In the 1X mode there is one sample per bit. A character has a start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and a stop bit.

A start edge is confirmed halfway through the start bit. If the line is high again by then, the edge is a false start and is dropped. After a framing error, the search for the next start bit resumes half a bit time later.

A character whose bits are all zero is reported as the start of a break, with its own strobe. When the line returns to mark, a separate strobe reports the end of the break. Each character can also be compared with a programmed value, which raises a match strobe.

A delivered character waits in a single holding register until the consumer pulses `rx_ack`. If a new character arrives before that, it overwrites the held one and carries an overrun flag. The line is assumed to be already synchronous to `clk`. Clock generation and buffering are outside the block.

Top module: `serial_rx_brk`

## Requirements
- R1: After reset, `rx_valid`, `rx_perr`, `rx_ferr`, `rx_ovr`, `brk_start`, `brk_end` and `cmp_match` are all 0.
- R2: The number of data bits is 5 + `cfg_len` (0 to 3), received least significant bit first. `rx_data` holds them right-aligned, with all bits above the character length at 0.
- R3: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_type` selects the expected value: 00 even, 01 odd, 10 always 0, 11 always 1. `rx_perr` is 1 when the received parity bit differs from the expected value, and is always 0 with parity off.
- R4: In 16X mode, a low sample starts a character only if the line is still low at the 8th sample (7 ticks after detection). Otherwise nothing is delivered and the receiver returns to idle.
- R5: A stop bit sampled low sets `rx_ferr`. For a character that is not a break, the search for a new start bit begins 8 ticks after the stop sample, so a start bit that directly follows the bad stop bit is still received correctly.
- R6: A character with all data bits, the parity bit (if enabled) and the stop bit at 0 is a break. It is delivered with `rx_data`=0 and `rx_ferr`=1, and `brk_start` pulses for one cycle. `brk_end` pulses once, after the line has been high for 8 consecutive ticks (1 tick in 1X mode). Shorter high periods are ignored.
- R7: With `cmp_en`=1, `cmp_match` pulses together with the delivery of a non-break character whose data bits, within the character length, equal the same bits of `cmp_value`. Value bits above the length are ignored. There is no match with `cmp_en`=0 or for a break.
- R8: A character that completes while `rx_valid` is 1 and `rx_ack` is 0 replaces the held character and sets `rx_ovr`=1. An `rx_ack` pulse with no completion in the same cycle clears `rx_valid`.
- R9: With `cfg_x1`=1, each tick is one bit time. A single low sample starts a character, with no false-start filter, and each following tick samples the next bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Sample tick (16 per bit, or 1 per bit in 1X mode) |
| rx_line | input | 1 | Serial line, idle high, synchronous to clk |
| cfg_x1 | input | 1 | 1 selects one sample per bit |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_type | input | 2 | 00 even, 01 odd, 10 zero, 11 one |
| cmp_en | input | 1 | Enables the match strobe |
| cmp_value | input | 8 | Value compared with each character |
| rx_ack | input | 1 | Consumer takes the held character |
| rx_valid | output | 1 | A character is held |
| rx_data | output | 8 | Held character, right-aligned |
| rx_perr | output | 1 | Parity error of the held character |
| rx_ferr | output | 1 | Framing error of the held character |
| rx_ovr | output | 1 | Held character overwrote an unread one |
| brk_start | output | 1 | One-cycle strobe: break received |
| brk_end | output | 1 | One-cycle strobe: line back to mark after a break |
| cmp_match | output | 1 | One-cycle strobe: character matched |

## Verification
The stop-bit sample of an all-zero character drives several results in the same cycle: delivery of the character, the framing flag, the break-start strobe and the compare decision. The bench sends a break while compare is enabled with a value of zero. It then checks three things: exactly one `brk_start` pulse, no `cmp_match`, and a held character of zero with `rx_ferr` set. A second coincidence is a framing error followed at once by the next start bit, with no idle time between them. That character must arrive intact. This shows the half-bit search after the error does not lose the start edge.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_HUNT,
      ST_BRK
   } rx_state_e;

   typedef enum logic [1:0] {
      PAR_EVEN = 2'd0,
      PAR_ODD  = 2'd1,
      PAR_ZERO = 2'd2,
      PAR_ONE  = 2'd3
   } par_type_e;

   // expected parity bit given the xor of the data bits
   function automatic logic exp_parity(input logic [1:0] ptype, input logic data_xor);
      case (ptype)
         PAR_EVEN: exp_parity = data_xor;
         PAR_ODD:  exp_parity = ~data_xor;
         PAR_ZERO: exp_parity = 1'b0;
         default:  exp_parity = 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
   import serial_rx_pkg::*;
#(
   parameter int OVS      = 16,
   parameter int MAX_BITS = 8,
   parameter int MIN_BITS = 5,
   parameter int LW       = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                rxd,
   input  logic                cfg_x1,
   input  logic [LW-1:0]       cfg_len,
   input  logic                cfg_par_en,
   input  logic [1:0]          cfg_par_type,
   output logic                done,
   output logic [MAX_BITS-1:0] char_data,
   output logic                char_perr,
   output logic                char_ferr,
   output logic                char_brk,
   output logic                brk_start,
   output logic                brk_end
);

   localparam int CW = $clog2(OVS);
   localparam int IW = $clog2(MAX_BITS);
   localparam logic [CW-1:0] BIT_LAST  = CW'(OVS - 1);
   localparam logic [CW-1:0] HALF_LAST = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] CONF_LAST = CW'(OVS / 2 - 2);

   rx_state_e             state;
   logic [CW-1:0]         cnt;
   logic [IW-1:0]         idx;
   logic [MAX_BITS-1:0]   shreg;
   logic                  par_q;
   logic                  brk_start_q, brk_end_q;

   logic [CW-1:0]         bit_last;
   logic [CW-1:0]         brk_last;
   logic [IW-1:0]         last_idx;
   logic                  bit_end;

   always_comb begin
      bit_last = cfg_x1 ? '0 : BIT_LAST;
      brk_last = cfg_x1 ? '0 : HALF_LAST;
      last_idx = IW'(MIN_BITS - 1) + IW'(cfg_len);
      bit_end  = tick && (cnt == bit_last);
   end

   always_comb begin
      done      = bit_end && (state == ST_STOP);
      char_data = shreg;
      char_ferr = ~rxd;
      char_perr = cfg_par_en && (par_q != exp_parity(cfg_par_type, ^shreg));
      char_brk  = ~rxd && (shreg == '0) && !(cfg_par_en && par_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cnt         <= '0;
         idx         <= '0;
         shreg       <= '0;
         par_q       <= 1'b0;
         brk_start_q <= 1'b0;
         brk_end_q   <= 1'b0;
      end else begin
         brk_start_q <= 1'b0;
         brk_end_q   <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (tick && !rxd) begin
                  state <= cfg_x1 ? ST_DATA : ST_START;
                  cnt   <= '0;
                  idx   <= '0;
                  shreg <= '0;
                  par_q <= 1'b0;
               end
            end
            ST_START: begin
               if (tick) begin
                  if (cnt == CONF_LAST) begin
                     cnt   <= '0;
                     state <= rxd ? ST_IDLE : ST_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_DATA: begin
               if (bit_end) begin
                  cnt        <= '0;
                  shreg[idx] <= rxd;
                  if (idx == last_idx) begin
                     state <= cfg_par_en ? ST_PAR : ST_STOP;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_PAR: begin
               if (bit_end) begin
                  cnt   <= '0;
                  par_q <= rxd;
                  state <= ST_STOP;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_STOP: begin
               if (bit_end) begin
                  cnt <= '0;
                  if (rxd) begin
                     state <= ST_IDLE;
                  end else if (char_brk) begin
                     state       <= ST_BRK;
                     brk_start_q <= 1'b1;
                  end else begin
                     state <= ST_HUNT;
                  end
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_HUNT: begin
               if (cfg_x1) begin
                  state <= ST_IDLE;
               end else if (tick) begin
                  if (cnt == HALF_LAST) begin
                     cnt   <= '0;
                     state <= ST_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_BRK: begin
               if (tick) begin
                  if (!rxd) begin
                     cnt <= '0;
                  end else if (cnt == brk_last) begin
                     cnt       <= '0;
                     state     <= ST_IDLE;
                     brk_end_q <= 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign brk_start = brk_start_q;
   assign brk_end   = brk_end_q;

   // R4: data phase entered from the start check only while the line is low
   p_start_confirm_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA && $past(state) == ST_START) |-> $past(!rxd));

   // R5: the hunt wait follows only a stop bit sampled low
   p_hunt_after_ferr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HUNT && $past(state) != ST_HUNT) |-> $past(state == ST_STOP && !rxd));

   // R9: idle goes straight to data only in 1X mode
   p_x1_direct_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA && $past(state) == ST_IDLE) |-> $past(cfg_x1));

   // R6: break end only ever leaves the break state
   p_brk_end_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      brk_end |-> ($past(state) == ST_BRK && state == ST_IDLE));

endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold #(
   parameter int MAX_BITS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                done,
   input  logic [MAX_BITS-1:0] in_data,
   input  logic                in_perr,
   input  logic                in_ferr,
   input  logic                ack,
   output logic                full,
   output logic [MAX_BITS-1:0] out_data,
   output logic                out_perr,
   output logic                out_ferr,
   output logic                out_ovr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full     <= 1'b0;
         out_data <= '0;
         out_perr <= 1'b0;
         out_ferr <= 1'b0;
         out_ovr  <= 1'b0;
      end else if (done) begin
         full     <= 1'b1;
         out_data <= in_data;
         out_perr <= in_perr;
         out_ferr <= in_ferr;
         out_ovr  <= full && !ack;
      end else if (ack) begin
         full <= 1'b0;
      end
   end

   // R8: unread character overwritten sets the overrun flag
   p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && full && !ack) |=> (full && out_ovr));

   // R8: a plain acknowledge empties the holding register
   p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !done) |=> !full);

endmodule

// File: rtl/serial_rx_cmp.sv
module serial_rx_cmp #(
   parameter int MAX_BITS = 8,
   parameter int MIN_BITS = 5,
   parameter int LW       = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                done,
   input  logic                is_brk,
   input  logic [LW-1:0]       cfg_len,
   input  logic                cmp_en,
   input  logic [MAX_BITS-1:0] cmp_value,
   input  logic [MAX_BITS-1:0] char_data,
   output logic                match
);

   logic [MAX_BITS-1:0] mask;
   logic                eq;

   always_comb begin
      for (int i = 0; i < MAX_BITS; i++) begin
         mask[i] = (i < MIN_BITS + int'(cfg_len));
      end
      eq = (((char_data ^ cmp_value) & mask) == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match <= 1'b0;
      else        match <= done && cmp_en && !is_brk && eq;
   end

   // R7: a match strobe is only produced when compare was enabled
   p_match_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      match |-> $past(cmp_en && done));

endmodule

// File: rtl/serial_rx_brk.sv
module serial_rx_brk
   import serial_rx_pkg::*;
#(
   parameter int OVS      = 16,
   parameter int MAX_BITS = 8,
   parameter int MIN_BITS = 5,
   parameter bit HAS_CMP  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sample_en,
   input  logic       rx_line,
   input  logic       cfg_x1,
   input  logic [1:0] cfg_len,
   input  logic       cfg_par_en,
   input  logic [1:0] cfg_par_type,
   input  logic       cmp_en,
   input  logic [7:0] cmp_value,
   input  logic       rx_ack,
   output logic       rx_valid,
   output logic [7:0] rx_data,
   output logic       rx_perr,
   output logic       rx_ferr,
   output logic       rx_ovr,
   output logic       brk_start,
   output logic       brk_end,
   output logic       cmp_match
);

   localparam int LW = 2;

   if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("OVS must be a power of two of at least 4");
   end
   if (MAX_BITS != 8 || MIN_BITS < 1 || MIN_BITS + 3 != MAX_BITS) begin : g_bad_len
      $error("character length range must be MIN_BITS..MIN_BITS+3 with MAX_BITS 8");
   end

   logic                done;
   logic [MAX_BITS-1:0] char_data;
   logic                char_perr, char_ferr, char_brk;

   serial_rx_frame #(
      .OVS(OVS), .MAX_BITS(MAX_BITS), .MIN_BITS(MIN_BITS), .LW(LW)
   ) u_frame (
      .clk(clk), .rst_n(rst_n), .tick(sample_en), .rxd(rx_line),
      .cfg_x1(cfg_x1), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
      .cfg_par_type(cfg_par_type), .done(done), .char_data(char_data),
      .char_perr(char_perr), .char_ferr(char_ferr), .char_brk(char_brk),
      .brk_start(brk_start), .brk_end(brk_end)
   );

   serial_rx_hold #(.MAX_BITS(MAX_BITS)) u_hold (
      .clk(clk), .rst_n(rst_n), .done(done), .in_data(char_data),
      .in_perr(char_perr), .in_ferr(char_ferr), .ack(rx_ack),
      .full(rx_valid), .out_data(rx_data), .out_perr(rx_perr),
      .out_ferr(rx_ferr), .out_ovr(rx_ovr)
   );

   if (HAS_CMP) begin : g_cmp
      serial_rx_cmp #(.MAX_BITS(MAX_BITS), .MIN_BITS(MIN_BITS), .LW(LW)) u_cmp (
         .clk(clk), .rst_n(rst_n), .done(done), .is_brk(char_brk),
         .cfg_len(cfg_len), .cmp_en(cmp_en), .cmp_value(cmp_value),
         .char_data(char_data), .match(cmp_match)
      );
   end else begin : g_no_cmp
      logic unused_cmp;
      assign unused_cmp = cmp_en ^ (^cmp_value);
      assign cmp_match  = 1'b0;
   end

   // R6: break start comes with a held zero character flagged as framing error
   p_brk_char_r6: assert property (@(posedge clk) disable iff (!rst_n)
      brk_start |-> (rx_valid && rx_ferr && rx_data == '0));

   // R6: start and end of a break never coincide
   p_brk_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(brk_start && brk_end));

   // R7: a match never accompanies a break and always has a held character
   p_match_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_match |-> (rx_valid && !brk_start));

endmodule

// File: tb/serial_rx_brk_tb.sv
module serial_rx_brk_tb;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sample_en = 1'b0;
   logic       rx_line = 1'b1;
   logic       cfg_x1 = 1'b0;
   logic [1:0] cfg_len = 2'd3;
   logic       cfg_par_en = 1'b0;
   logic [1:0] cfg_par_type = 2'd0;
   logic       cmp_en = 1'b0;
   logic [7:0] cmp_value = 8'h00;
   logic       rx_ack = 1'b0;
   logic       rx_valid, rx_perr, rx_ferr, rx_ovr, brk_start, brk_end, cmp_match;
   logic [7:0] rx_data;

   int n_tests = 0;
   int n_fail  = 0;
   int n_bs = 0, n_be = 0, n_m = 0;
   logic [1:0] div = 2'd0;

   serial_rx_brk u_dut (
      .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rx_line(rx_line),
      .cfg_x1(cfg_x1), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
      .cfg_par_type(cfg_par_type), .cmp_en(cmp_en), .cmp_value(cmp_value),
      .rx_ack(rx_ack), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_ovr(rx_ovr),
      .brk_start(brk_start), .brk_end(brk_end), .cmp_match(cmp_match)
   );

   always #(CLK_P / 2) clk = ~clk;

   always @(negedge clk) begin
      div       <= div + 2'd1;
      sample_en <= (div == 2'd3);
   end

   always @(posedge clk) begin
      if (brk_start) n_bs++;
      if (brk_end)   n_be++;
      if (cmp_match) n_m++;
   end

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         while (!sample_en) @(posedge clk);
      end
      @(negedge clk);
   endtask

   task automatic put_bit(input logic v, input int n);
      rx_line = v;
      wait_ticks(n);
   endtask

   task automatic ack_char();
      rx_ack = 1'b1;
      @(negedge clk);
      rx_ack = 1'b0;
   endtask

   function automatic logic par_of(input logic [1:0] t, input logic [7:0] d);
      case (t)
         2'd0: par_of = ^d;
         2'd1: par_of = ~(^d);
         2'd2: par_of = 1'b0;
         default: par_of = 1'b1;
      endcase
   endfunction

   // whole frame; nb data bits; parity bit value given explicitly
   task automatic send(input logic [7:0] d, input int nb, input bit pe,
                       input logic pbit, input logic stop, input int tpb);
      put_bit(1'b0, tpb);
      for (int i = 0; i < nb; i++) put_bit(d[i], tpb);
      if (pe) put_bit(pbit, tpb);
      put_bit(stop, tpb);
   endtask

   task automatic t_reset();
      check("R1 valid", rx_valid, 0);
      check("R1 flags", {rx_perr, rx_ferr, rx_ovr}, 0);
      check("R1 strobes", {brk_start, brk_end, cmp_match}, 0);
   endtask

   task automatic t_lengths();
      logic [7:0] pat [4];
      pat[0] = 8'hFF; pat[1] = 8'h2D; pat[2] = 8'h5A; pat[3] = 8'hC3;
      cfg_par_en = 1'b0;
      for (int l = 0; l < 4; l++) begin
         cfg_len = 2'(l);
         send(pat[l], 5 + l, 0, 1'b0, 1'b1, 16);
         check("R2 valid", rx_valid, 1);
         check("R2 data", rx_data, int'(pat[l] & 8'((1 << (5 + l)) - 1)));
         check("R2 flags", {rx_perr, rx_ferr, rx_ovr}, 0);
         ack_char();
      end
      cfg_len = 2'd3;
   endtask

   task automatic t_parity();
      cfg_len = 2'd2;
      cfg_par_en = 1'b1;
      for (int t = 0; t < 4; t++) begin
         for (int bad = 0; bad < 2; bad++) begin
            logic [7:0] d;
            d = 8'h35 + 8'(t * 7);
            d[7] = 1'b0;
            cfg_par_type = 2'(t);
            send(d, 7, 1, par_of(2'(t), d) ^ logic'(bad), 1'b1, 16);
            check("R3 data", rx_data, int'(d));
            check("R3 perr", rx_perr, bad);
            ack_char();
         end
      end
      cfg_par_en = 1'b0;
      cfg_len = 2'd3;
   endtask

   task automatic t_false_start();
      put_bit(1'b0, 4);
      put_bit(1'b1, 24);
      check("R4 glitch ignored", rx_valid, 0);
      send(8'hA5, 8, 0, 1'b0, 1'b1, 16);
      check("R4 next char", rx_data, 8'hA5);
      check("R4 next valid", rx_valid, 1);
      ack_char();
   endtask

   task automatic t_ferr_resync();
      int bs0;
      bs0 = n_bs;
      send(8'h55, 8, 0, 1'b0, 1'b0, 16);
      check("R5 ferr", rx_ferr, 1);
      check("R5 data", rx_data, 8'h55);
      check("R5 no break", n_bs - bs0, 0);
      ack_char();
      send(8'h3C, 8, 0, 1'b0, 1'b1, 16);
      check("R5 resync data", rx_data, 8'h3C);
      check("R5 resync ferr", rx_ferr, 0);
      ack_char();
   endtask

   task automatic t_break();
      int bs0, be0, m0;
      bs0 = n_bs; be0 = n_be; m0 = n_m;
      cmp_en = 1'b1; cmp_value = 8'h00;
      send(8'h00, 8, 0, 1'b0, 1'b0, 16);
      put_bit(1'b0, 32);
      check("R6 brk start", n_bs - bs0, 1);
      check("R6 brk char", {rx_data, rx_ferr}, 1);
      check("R7 no match on break", n_m - m0, 0);
      check("R6 no early end", n_be - be0, 0);
      ack_char();
      put_bit(1'b1, 4);
      put_bit(1'b0, 4);
      check("R6 short mark ignored", n_be - be0, 0);
      put_bit(1'b1, 12);
      check("R6 brk end", n_be - be0, 1);
      check("R6 single start", n_bs - bs0, 1);
      cmp_en = 1'b0;
   endtask

   task automatic t_match();
      int m0;
      m0 = n_m;
      cmp_en = 1'b1; cmp_value = 8'h3A;
      send(8'h3A, 8, 0, 1'b0, 1'b1, 16);
      check("R7 match", n_m - m0, 1);
      ack_char();
      send(8'h3B, 8, 0, 1'b0, 1'b1, 16);
      check("R7 mismatch", n_m - m0, 1);
      ack_char();
      cmp_en = 1'b0;
      send(8'h3A, 8, 0, 1'b0, 1'b1, 16);
      check("R7 disabled", n_m - m0, 1);
      check("R7 disabled char", rx_data, 8'h3A);
      ack_char();
      cmp_en = 1'b1; cmp_value = 8'hFA; cfg_len = 2'd0;
      send(8'h1A, 5, 0, 1'b0, 1'b1, 16);
      check("R7 upper bits ignored", n_m - m0, 2);
      ack_char();
      cmp_en = 1'b0; cfg_len = 2'd3;
   endtask

   task automatic t_overrun();
      send(8'h11, 8, 0, 1'b0, 1'b1, 16);
      check("R8 first ovr", rx_ovr, 0);
      send(8'h22, 8, 0, 1'b0, 1'b1, 16);
      check("R8 overwrite", rx_data, 8'h22);
      check("R8 ovr", rx_ovr, 1);
      ack_char();
      check("R8 ack clears", rx_valid, 0);
      send(8'h33, 8, 0, 1'b0, 1'b1, 16);
      check("R8 ovr cleared", rx_ovr, 0);
      check("R8 data", rx_data, 8'h33);
      ack_char();
   endtask

   task automatic t_x1();
      cfg_x1 = 1'b1;
      put_bit(1'b1, 3);
      cfg_par_en = 1'b1; cfg_par_type = 2'd0;
      send(8'h96, 8, 1, par_of(2'd0, 8'h96), 1'b1, 1);
      put_bit(1'b1, 2);
      check("R9 data", rx_data, 8'h96);
      check("R9 perr", rx_perr, 0);
      check("R9 valid", rx_valid, 1);
      ack_char();
      cfg_par_en = 1'b0;
      send(8'h4E, 8, 0, 1'b0, 1'b1, 1);
      check("R9 second", rx_data, 8'h4E);
      ack_char();
      cfg_x1 = 1'b0;
      put_bit(1'b1, 4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      put_bit(1'b1, 20);
      t_reset();
      t_lengths();
      t_parity();
      t_false_start();
      t_ferr_resync();
      t_break();
      t_match();
      t_overrun();
      t_x1();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule